// File: doc/BRIEF.md
# Double-Buffered OUT Endpoint Buffer

This block sits between the receive side of a USB device serial interface engine and a host processor. It holds incoming OUT data packets in two ping-pong slots of 128 bytes each, 256 bytes in all. The serial side marks each packet with a start strobe, a stream of byte strobes and an end strobe. At the start strobe the block decides whether the packet is taken or refused. It reports that decision one cycle after the end strobe as an ACK or NAK handshake.

The processor empties the oldest waiting packet one byte per read of a 32-bit data register. A read pulse loads the next byte into the low eight bits of the register and zeroes the upper bits. Once the last byte of a slot has been read, that slot is free for a new packet. Each accepted end of packet sets a sticky interrupt, which the processor clears with a clear pulse. A packet that arrives while no slot is completely empty is refused. It leaves the stored data untouched.

Top module: `usb_out_pingpong`

## Requirements
- R1: After reset, rd_data is 0x00000000, and irq, pkt_avail, rd_ovf, hs_valid and will_nak are all 0.
- R2: The bytes of an accepted packet come out in arrival order. Each rd_en pulse loads rd_data with {24'h0, byte}, valid from the cycle after the pulse.
- R3: One cycle after the end strobe of an accepted packet, irq is 1. It stays 1 until an irq_clr pulse arrives. An end strobe in the same cycle as irq_clr leaves irq at 1.
- R4: One cycle after an end strobe, hs_valid is 1 for one cycle. hs_nak is 0 (ACK) if a completely empty slot existed at the packet's start strobe, and 1 (NAK) otherwise.
- R5: will_nak is 1 exactly while both slots hold a packet, including a partly read one. Every packet started in that state is refused. Acceptance resumes after the last byte of a slot has been read.
- R6: A refused packet writes no byte into storage and does not set irq.
- R7: Two waiting packets are presented in the order they arrived.
- R8: A packet longer than 128 bytes keeps its first 128 bytes. rd_ovf is 1 while that packet is the one being read.
- R9: An rd_en pulse while pkt_avail is 0 returns rd_data = 0 and moves no read position.
- R10: A zero-length packet is acknowledged and sets irq, but it occupies no slot.
- R11: pkt_avail is 1 while the oldest slot holds unread bytes. After its last byte is read, pkt_avail shows the other slot's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_sop | input | 1 | Start-of-packet strobe from the serial side |
| sie_valid | input | 1 | Data byte strobe |
| sie_data | input | 8 | Received data byte |
| sie_eop | input | 1 | End-of-packet strobe |
| hs_valid | output | 1 | Handshake result valid, one cycle |
| hs_nak | output | 1 | 1 = NAK, 0 = ACK, qualified by hs_valid |
| will_nak | output | 1 | A packet started now would be refused |
| rd_en | input | 1 | Data register read pulse |
| rd_data | output | 32 | Data register, byte in bits 7:0, upper bits zero |
| pkt_avail | output | 1 | A packet is waiting to be read |
| rd_ovf | output | 1 | The packet being read was truncated |
| irq_clr | input | 1 | Interrupt clear pulse |
| irq | output | 1 | Sticky packet-received interrupt |

## Verification
The assertions assume a well-formed serial stream. Each packet opens with a lone start strobe, carries byte strobes on later cycles and closes with a lone end strobe. Strobes never share a cycle, and no start strobe coincides with the read that frees a slot. The bench drives every packet through one task that keeps this framing, and it places reads only between packets. Under those conditions the assertions hold: the writes and commits only ever target a free slot, and with a single packet waiting it is always the one at the read position.

// File: rtl/oep_pkg.sv
package oep_pkg;
  localparam int unsigned SLOT_COUNT = 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  // A new packet may be taken only when some slot is completely empty.
  function automatic logic any_slot_open(input logic [SLOT_COUNT-1:0] full);
    return ~(&full);
  endfunction

  // Ping-pong successor of a slot index.
  function automatic logic next_slot(input logic cur);
    return ~cur;
  endfunction
endpackage

// File: rtl/oep_rx.sv
module oep_rx
  import oep_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 128,
  localparam int unsigned CNT_W = $clog2(SLOT_BYTES + 1),
  localparam int unsigned PTR_W = $clog2(SLOT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sie_sop,
  input  logic             sie_valid,
  input  logic             sie_eop,
  input  logic             slot_open,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len,
  output logic             commit_ovf,
  output logic             hs_valid,
  output logic             hs_nak
);
  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  function automatic logic has_room(input logic [CNT_W-1:0] c);
    return c < CNT_W'(SLOT_BYTES);
  endfunction

  logic byte_in;
  logic end_in;
  assign byte_in    = sie_valid && !sie_sop && !sie_eop;
  assign end_in     = sie_eop && !sie_sop;
  assign wr_en      = byte_in && (state == RX_TAKE) && has_room(cnt);
  assign wr_addr    = cnt[PTR_W-1:0];
  assign commit     = end_in && (state == RX_TAKE);
  assign commit_len = cnt;
  assign commit_ovf = ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      ovf      <= 1'b0;
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
    end else begin
      hs_valid <= end_in && (state != RX_IDLE);
      hs_nak   <= end_in && (state == RX_DROP);
      if (sie_sop) begin
        state <= slot_open ? RX_TAKE : RX_DROP;
        cnt   <= '0;
        ovf   <= 1'b0;
      end else if (sie_eop) begin
        state <= RX_IDLE;
      end else if (byte_in && state == RX_TAKE) begin
        if (has_room(cnt)) cnt <= cnt + 1'b1;
        else               ovf <= 1'b1;
      end
    end
  end

  // R8: the byte count never passes one slot
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLOT_BYTES));
  // R8: overflow is flagged only once the slot is full
  p_ovf_at_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == CNT_W'(SLOT_BYTES)));
  // R4: a NAK is always part of a handshake
  p_nak_in_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> hs_valid);
endmodule

// File: rtl/oep_slot_mem.sv
module oep_slot_mem
  import oep_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 128,
  localparam int unsigned PTR_W = $clog2(SLOT_BYTES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_slot,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_slot,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_byte
);
  logic [7:0] rd_lane [SLOT_COUNT];

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    logic [7:0] store [SLOT_BYTES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == 1'(s))) store[wr_addr] <= wr_data;
    end
    assign rd_lane[s] = store[rd_addr];
  end

  assign rd_byte = rd_lane[rd_slot];
endmodule

// File: rtl/oep_drain.sv
module oep_drain #(
  parameter int unsigned SLOT_BYTES = 128,
  localparam int unsigned CNT_W = $clog2(SLOT_BYTES + 1),
  localparam int unsigned PTR_W = $clog2(SLOT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             avail,
  input  logic [CNT_W-1:0] len,
  input  logic [7:0]       rd_byte,
  output logic [PTR_W-1:0] rd_addr,
  output logic             release_slot,
  output logic [31:0]      rd_data
);
  logic [CNT_W-1:0] ptr;
  logic             take;

  function automatic logic at_last(input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] l);
    return (p + 1'b1) == l;
  endfunction

  assign take         = rd_en && avail;
  assign release_slot = take && at_last(ptr, len);
  assign rd_addr      = ptr[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      rd_data <= '0;
    end else if (take) begin
      rd_data <= {24'h0, rd_byte};
      ptr     <= release_slot ? '0 : ptr + 1'b1;
    end else if (rd_en) begin
      rd_data <= '0;
    end
  end

  // R11: the read position stays inside the waiting packet
  p_ptr_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> (ptr < len));
  // R9: a read with nothing waiting returns zero and keeps the position
  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !avail) |=> ((rd_data == 32'h0) && $stable(ptr)));
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
  import oep_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sie_sop,
  input  logic        sie_valid,
  input  logic [7:0]  sie_data,
  input  logic        sie_eop,
  output logic        hs_valid,
  output logic        hs_nak,
  output logic        will_nak,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        pkt_avail,
  output logic        rd_ovf,
  input  logic        irq_clr,
  output logic        irq
);
  localparam int unsigned CNT_W = $clog2(SLOT_BYTES + 1);
  localparam int unsigned PTR_W = $clog2(SLOT_BYTES);

  logic [SLOT_COUNT-1:0] full;
  logic [SLOT_COUNT-1:0] ovf_q;
  logic [CNT_W-1:0]      len_q [SLOT_COUNT];
  logic                  wr_sel;
  logic                  rd_sel;

  logic             slot_open;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic             commit;
  logic [CNT_W-1:0] commit_len;
  logic             commit_ovf;
  logic             commit_slot;
  logic [PTR_W-1:0] rd_addr;
  logic [7:0]       rd_byte;
  logic             release_slot;

  assign slot_open   = any_slot_open(full);
  assign will_nak    = ~slot_open;
  assign commit_slot = commit && (commit_len != '0);
  assign pkt_avail   = full[rd_sel];
  assign rd_ovf      = full[rd_sel] & ovf_q[rd_sel];

  oep_rx #(.SLOT_BYTES(SLOT_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sie_sop(sie_sop), .sie_valid(sie_valid), .sie_eop(sie_eop),
    .slot_open(slot_open),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .commit(commit), .commit_len(commit_len), .commit_ovf(commit_ovf),
    .hs_valid(hs_valid), .hs_nak(hs_nak)
  );

  oep_slot_mem #(.SLOT_BYTES(SLOT_BYTES)) u_mem (
    .clk(clk),
    .wr_en(wr_en), .wr_slot(wr_sel), .wr_addr(wr_addr), .wr_data(sie_data),
    .rd_slot(rd_sel), .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  oep_drain #(.SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .avail(pkt_avail), .len(len_q[rd_sel]),
    .rd_byte(rd_byte), .rd_addr(rd_addr),
    .release_slot(release_slot), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= '0;
      ovf_q  <= '0;
      wr_sel <= 1'b0;
      rd_sel <= 1'b0;
      irq    <= 1'b0;
      for (int s = 0; s < SLOT_COUNT; s++) len_q[s] <= '0;
    end else begin
      if (commit_slot) begin
        full[wr_sel]  <= 1'b1;
        ovf_q[wr_sel] <= commit_ovf;
        len_q[wr_sel] <= commit_len;
        wr_sel        <= next_slot(wr_sel);
      end
      if (release_slot) begin
        full[rd_sel] <= 1'b0;
        rd_sel       <= next_slot(rd_sel);
      end
      if (commit)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R5: a completed packet only lands in an empty slot
  p_commit_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_slot |-> !full[wr_sel]);
  // R6: no byte is stored into an occupied slot
  p_write_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full[wr_sel]);
  // R3: an accepted end of packet raises the interrupt
  p_irq_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);
  // R3: the interrupt holds until cleared
  p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R7: a lone waiting packet is always the one at the read position
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(full) == 1) |-> full[rd_sel]);
endmodule

// File: tb/usb_out_pingpong_bench.sv
module usb_out_pingpong_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sie_sop = 1'b0, sie_valid = 1'b0, sie_eop = 1'b0;
  logic [7:0]  sie_data = 8'h00;
  logic        hs_valid, hs_nak, will_nak;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        pkt_avail, rd_ovf;
  logic        irq_clr = 1'b0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_out_pingpong u_usb_out_pingpong (
    .clk(clk), .rst_n(rst_n),
    .sie_sop(sie_sop), .sie_valid(sie_valid), .sie_data(sie_data), .sie_eop(sie_eop),
    .hs_valid(hs_valid), .hs_nak(hs_nak), .will_nak(will_nak),
    .rd_en(rd_en), .rd_data(rd_data), .pkt_avail(pkt_avail), .rd_ovf(rd_ovf),
    .irq_clr(irq_clr), .irq(irq)
  );

  // Each entry: {length, first byte}; byte i of a packet is first + i.
  localparam logic [15:0] VEC [6] = '{
    {8'd1,   8'hA0}, {8'd5,   8'h10}, {8'd64, 8'h33},
    {8'd128, 8'h80}, {8'd127, 8'hF0}, {8'd3,  8'hFE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_packet(input int n, input logic [7:0] base, input logic clr);
    @(negedge clk); sie_sop = 1'b1;
    @(negedge clk); sie_sop = 1'b0;
    for (int i = 0; i < n; i++) begin
      sie_valid = 1'b1; sie_data = base + 8'(i);
      @(negedge clk);
    end
    sie_valid = 1'b0; sie_eop = 1'b1; irq_clr = clr;
    @(negedge clk); sie_eop = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic read_byte(output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic drain_check(input string tag, input int n, input logic [7:0] base);
    logic [31:0] v;
    int bad = 0;
    logic [31:0] first_bad_act = 0, first_bad_exp = 0;
    for (int i = 0; i < n; i++) begin
      read_byte(v);
      if (v !== {24'h0, base + 8'(i)} && bad == 0) begin
        bad = 1; first_bad_act = v; first_bad_exp = {24'h0, base + 8'(i)};
      end
    end
    if (bad != 0) check(tag, first_bad_act, first_bad_exp);
    else          check(tag, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 irq/avail/ovf/hs/will_nak",
          {27'h0, irq, pkt_avail, rd_ovf, hs_valid, will_nak}, 32'h0);

    // Table walk: one packet in, check handshake and interrupt, drain it all.
    for (int k = 0; k < 6; k++) begin
      send_packet(int'(VEC[k][15:8]), VEC[k][7:0], 1'b0);
      check("R4 ACK handshake", {30'h0, hs_valid, hs_nak}, 32'h2);
      check("R3 irq after end", {31'h0, irq}, 32'h1);
      check("R11 avail after packet", {31'h0, pkt_avail}, 32'h1);
      drain_check("R2 byte order", int'(VEC[k][15:8]), VEC[k][7:0]);
      check("R11 released after last byte", {31'h0, pkt_avail}, 32'h0);
      clear_irq();
      check("R3 irq cleared", {31'h0, irq}, 32'h0);
    end

    // R9: read with nothing waiting
    read_byte(v);
    check("R9 idle read zero", v, 32'h0);
    send_packet(2, 8'h55, 1'b0);
    drain_check("R9 pointer unmoved by idle read", 2, 8'h55);
    clear_irq();

    // R5/R6/R7: fill both slots, refused packets, partial drain
    send_packet(4, 8'h10, 1'b0);
    check("R5 one slot used, will_nak", {31'h0, will_nak}, 32'h0);
    send_packet(4, 8'h20, 1'b0);
    check("R5 both used, will_nak", {31'h0, will_nak}, 32'h1);
    clear_irq();
    send_packet(4, 8'h30, 1'b0);
    check("R4 NAK handshake", {30'h0, hs_valid, hs_nak}, 32'h3);
    check("R6 no irq on refused", {31'h0, irq}, 32'h0);
    read_byte(v); check("R7 first packet first", v, 32'h10);
    read_byte(v); check("R7 second byte", v, 32'h11);
    check("R5 partial drain keeps NAK", {31'h0, will_nak}, 32'h1);
    send_packet(3, 8'h40, 1'b0);
    check("R5 NAK while partly drained", {30'h0, hs_valid, hs_nak}, 32'h3);
    drain_check("R6 first slot intact", 2, 8'h12);
    check("R5 NAK lifted after slot freed", {31'h0, will_nak}, 32'h0);
    drain_check("R7 R6 second packet intact", 4, 8'h20);
    check("R11 both drained", {31'h0, pkt_avail}, 32'h0);
    send_packet(1, 8'h66, 1'b0);
    check("R5 ACK again", {30'h0, hs_valid, hs_nak}, 32'h2);
    drain_check("R5 accepted after release", 1, 8'h66);
    clear_irq();

    // R8: overflow truncation
    send_packet(130, 8'h40, 1'b0);
    check("R8 rd_ovf set", {31'h0, rd_ovf}, 32'h1);
    drain_check("R8 first 128 kept", 128, 8'h40);
    check("R8 rd_ovf after drain", {30'h0, pkt_avail, rd_ovf}, 32'h0);
    clear_irq();
    send_packet(2, 8'h01, 1'b0);
    check("R8 normal packet no ovf", {31'h0, rd_ovf}, 32'h0);
    drain_check("R8 normal bytes", 2, 8'h01);
    clear_irq();

    // R10: zero-length packet
    send_packet(0, 8'h00, 1'b0);
    check("R10 ACK zero-length", {30'h0, hs_valid, hs_nak}, 32'h2);
    check("R10 irq zero-length", {31'h0, irq}, 32'h1);
    check("R10 no slot used", {31'h0, pkt_avail}, 32'h0);

    // R3: end strobe beats a simultaneous clear
    clear_irq();
    send_packet(1, 8'h77, 1'b1);
    check("R3 set wins over clear", {31'h0, irq}, 32'h1);
    @(negedge clk);
    check("R4 hs one cycle", {31'h0, hs_valid}, 32'h0);
    clear_irq();
    check("R3 cleared after", {31'h0, irq}, 32'h0);
    drain_check("R2 last packet", 1, 8'h77);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule